// File: doc/BRIEF.md
# Triggered Program-Flow Trace Buffer

The block sits beside a processor core and records the path the program takes at full core speed, one record per clock at most. Straight-line execution is not stored: sequential instructions only advance a run counter. A taken branch stores one word holding that run count and the low bits of the branch target. Full-address anchor records are forced when recording resumes and at a programmable spacing, so an off-chip decoder can rebuild the flow from any anchor onwards.

Records go into a circular RAM of `DEPTH` words. Start and stop events, typically from watchpoint comparators, gate recording. A trigger event splits the buffer: after the trigger, a programmed number of further records are written and capture then freezes. This leaves `DEPTH - post_count` words of history before the trigger once the ring has wrapped. A debugger later drains the buffer slowly through a small register port. That port has an auto-incrementing index, and index 0 is the oldest valid record.

Top module: `trace_capture_buffer`

## Requirements
- R1: The record produced by an instruction presented while recording is stored at the write pointer on that clock edge, and the write pointer then advances by one.
- R2: The first instruction recorded after recording is enabled produces an anchor record: bits [31:30] = 2'b10 and bits [29:0] = next-address[31:2]. The next address is the target for a taken branch and pc+4 otherwise. The run count is cleared.
- R3: A taken branch that does not produce an anchor stores bits [31:30] = 2'b01, [29:22] = the number of sequential instructions since the previous record, and [21:0] = target[23:2]. A sequential instruction that does not produce an anchor or overflow record stores nothing.
- R4: A sequential instruction that arrives with the run count at 255 stores {2'b11, 8'hFF, 22'h0}, and the run count restarts at 1.
- R5: When sync_every is nonzero and the number of records since the last anchor has reached it, the next recorded instruction produces an anchor in place of its normal record. A value of 0 disables periodic anchors.
- R6: The first trig_evt is latched. Records written in later cycles are counted, and when post_count of them have been written cap_done rises and no further record is stored. With post_count = 0, cap_done rises on the cycle after the trigger.
- R7: The buffer holds DEPTH words (DEPTH a power of two). buf_wrapped rises when the write pointer passes the last entry and stays high until reset.
- R8: start_evt and stop_evt act from the next cycle, and stop wins when both arrive together. rec_active reports recording enabled and capture not done.
- R9: A read of register 0 returns bit0 = done, bit1 = wrapped and bit2 = trigger seen. A read of register 3 returns the number of valid entries (DEPTH once wrapped).
- R10: Register 1 is the read index and is writable. A read of register 2 returns the entry at oldest+index on the next edge and then increments the index. The oldest entry is the write pointer once wrapped, otherwise entry 0.
- R11: After reset, the flags, the fill count and the index are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| instr_valid | input | 1 | An instruction retires this cycle |
| instr_pc | input | 32 | Address of the retiring instruction |
| instr_taken | input | 1 | The instruction is a taken branch |
| instr_target | input | 32 | Branch target when taken |
| start_evt | input | 1 | Enable recording from the next cycle |
| stop_evt | input | 1 | Disable recording from the next cycle |
| trig_evt | input | 1 | Trigger event |
| sync_every | input | 8 | Records between forced anchors, 0 = off |
| post_count | input | clog2(DEPTH)+1 | Records kept after the trigger |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | clog2(DEPTH) | Write data (read index) |
| bus_rdata | output | 32 | Registered read data |
| rec_active | output | 1 | Recording enabled and not done |
| cap_done | output | 1 | Post-trigger capture complete |
| buf_wrapped | output | 1 | Oldest entries have been overwritten |

## Verification
The encoder is driven with streams that have different taken-branch ratios. A branch-free run longer than 255 instructions followed by one branch isolates the overflow record from the count carried by the branch record. A dense stream with tight anchor spacing pushes the ring past its depth, which separates the oldest-first readout from a plain zero-based one. Trigger runs with a mid-size post count and with zero tell whether the post window counts writes rather than cycles. A stop/start sequence shows that idle instructions leave no trace and that recording resumes with an anchor.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam int CNT_W = 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  localparam logic [1:0] KIND_NONE   = 2'b00;
  localparam logic [1:0] KIND_BRANCH = 2'b01;
  localparam logic [1:0] KIND_SYNC   = 2'b10;
  localparam logic [1:0] KIND_RUN    = 2'b11;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_IDX  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_FILL = 2'd3
  } reg_sel_e;

  function automatic logic [31:0] pack_branch(input logic [CNT_W-1:0] n,
                                              input logic [31:0] tgt);
    return {KIND_BRANCH, n, tgt[23:2]};
  endfunction

  function automatic logic [31:0] pack_sync(input logic [31:0] addr);
    return {KIND_SYNC, addr[31:2]};
  endfunction

  function automatic logic [31:0] pack_run();
    return {KIND_RUN, CNT_MAX, 22'd0};
  endfunction
endpackage

// File: rtl/trace_rec_encoder.sv
module trace_rec_encoder
  import tcb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fire,
  input  logic        taken,
  input  logic        resync,
  input  logic [31:0] pc,
  input  logic [31:0] target,
  input  logic [7:0]  sync_every,
  output logic        rec_valid,
  output logic [31:0] rec_word
);
  logic [CNT_W-1:0] run_cnt;
  logic [7:0]       since;
  logic             pend;
  logic             sync_due;
  logic             cnt_full;
  logic [31:0]      next_pc;

  assign cnt_full = (run_cnt == CNT_MAX);
  assign sync_due = pend || (sync_every != 8'd0 && since >= sync_every);
  assign next_pc  = taken ? target : pc + 32'd4;

  always_comb begin
    rec_valid = 1'b0;
    rec_word  = '0;
    if (fire) begin
      if (sync_due) begin
        rec_valid = 1'b1;
        rec_word  = pack_sync(next_pc);
      end else if (taken) begin
        rec_valid = 1'b1;
        rec_word  = pack_branch(run_cnt, target);
      end else if (cnt_full) begin
        rec_valid = 1'b1;
        rec_word  = pack_run();
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      since   <= '0;
      pend    <= 1'b0;
    end else begin
      if (fire && sync_due) begin
        pend    <= 1'b0;
        since   <= '0;
        run_cnt <= '0;
      end else if (fire) begin
        if (taken)         run_cnt <= '0;
        else if (cnt_full) run_cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
        else               run_cnt <= run_cnt + 1'b1;
        if (rec_valid && since != 8'hFF) since <= since + 8'd1;
      end
      if (resync) pend <= 1'b1;
    end
  end

  // R3
  branch_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && taken |-> rec_valid && rec_word[31:30] != KIND_NONE);
endmodule

// File: rtl/trace_cap_ctl.sv
module trace_cap_ctl #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          trig_evt,
  input  logic          wr_fire,
  input  logic [PW-1:0] post_count,
  output logic          rec_on,
  output logic          resync,
  output logic          trig_seen,
  output logic          done
);
  logic [PW-1:0] post_n;

  assign resync = start_evt && !stop_evt && !rec_on && !done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_on    <= 1'b0;
      trig_seen <= 1'b0;
      done      <= 1'b0;
      post_n    <= '0;
    end else begin
      if (stop_evt)       rec_on <= 1'b0;
      else if (start_evt) rec_on <= 1'b1;
      if (trig_evt && !trig_seen && !done) begin
        trig_seen <= 1'b1;
        if (post_count == '0) done <= 1'b1;
      end
      if (wr_fire && trig_seen && !done) begin
        post_n <= post_n + 1'b1;
        if (post_n + 1'b1 == post_count) done <= 1'b1;
      end
    end
  end

  // R6
  done_after_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> trig_seen);
  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  // R8
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !rec_on);
endmodule

// File: rtl/trace_ring.sv
module trace_ring
  import tcb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [31:0]   wr_word,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [AW-1:0] idx_wdata,
  input  logic          st_done,
  input  logic          st_trig,
  output logic [31:0]   bus_rdata,
  output logic          wrapped
);
  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] idx;
  logic [AW-1:0] phys;
  logic [AW:0]   fill;

  assign phys = (wrapped ? wptr : '0) + idx;
  assign fill = wrapped ? (AW+1)'(DEPTH) : {1'b0, wptr};

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr      <= '0;
      wrapped   <= 1'b0;
      idx       <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_en) begin
        wptr <= wptr + 1'b1;
        if (wptr == AW'(DEPTH-1)) wrapped <= 1'b1;
      end
      if (bus_wr && bus_addr == SEL_IDX)       idx <= idx_wdata;
      else if (bus_rd && bus_addr == SEL_DATA) idx <= idx + 1'b1;
      if (bus_rd) begin
        case (bus_addr)
          SEL_STAT: bus_rdata <= {29'd0, st_trig, wrapped, st_done};
          SEL_IDX:  bus_rdata <= {{(32-AW){1'b0}}, idx};
          SEL_DATA: bus_rdata <= mem[phys];
          default:  bus_rdata <= {{(31-AW){1'b0}}, fill};
        endcase
      end
    end
  end

  // R7
  wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped |=> wrapped);
  // R1
  write_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wptr == $past(wptr) + 1'b1);
  // R10
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == SEL_DATA && !bus_wr |=> idx == $past(idx) + 1'b1);
endmodule

// File: rtl/trace_capture_buffer.sv
module trace_capture_buffer #(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     instr_valid,
  input  logic [31:0]              instr_pc,
  input  logic                     instr_taken,
  input  logic [31:0]              instr_target,
  input  logic                     start_evt,
  input  logic                     stop_evt,
  input  logic                     trig_evt,
  input  logic [7:0]               sync_every,
  input  logic [$clog2(DEPTH):0]   post_count,
  input  logic                     bus_rd,
  input  logic                     bus_wr,
  input  logic [1:0]               bus_addr,
  input  logic [$clog2(DEPTH)-1:0] bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic                     rec_active,
  output logic                     cap_done,
  output logic                     buf_wrapped
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic        rec_on, resync, trig_seen, fire;
  logic        rec_valid;
  logic [31:0] rec_word;

  assign fire       = instr_valid && rec_on && !cap_done;
  assign rec_active = rec_on && !cap_done;

  trace_cap_ctl #(.PW(PW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .trig_evt(trig_evt), .wr_fire(rec_valid), .post_count(post_count),
    .rec_on(rec_on), .resync(resync), .trig_seen(trig_seen), .done(cap_done)
  );

  trace_rec_encoder u_enc (
    .clk(clk), .rst_n(rst_n), .fire(fire), .taken(instr_taken),
    .resync(resync), .pc(instr_pc), .target(instr_target),
    .sync_every(sync_every), .rec_valid(rec_valid), .rec_word(rec_word)
  );

  trace_ring #(.DEPTH(DEPTH), .AW(AW)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(rec_valid), .wr_word(rec_word),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .idx_wdata(bus_wdata), .st_done(cap_done), .st_trig(trig_seen),
    .bus_rdata(bus_rdata), .wrapped(buf_wrapped)
  );

  // R6
  no_write_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |-> !rec_valid);
endmodule

// File: tb/tb_trace_capture_buffer.sv
`timescale 1ns/1ps
module tb_trace_capture_buffer;
  localparam int DEPTH = 64;
  localparam int AW = 6;
  localparam int PW = 7;

  logic clk = 0, rst_n = 0;
  logic instr_valid = 0, instr_taken = 0, start_evt = 0, stop_evt = 0, trig_evt = 0;
  logic [31:0] instr_pc = 0, instr_target = 0;
  logic [7:0] sync_every = 0;
  logic [PW-1:0] post_count = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [AW-1:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic rec_active, cap_done, buf_wrapped;

  trace_capture_buffer #(.DEPTH(DEPTH)) dut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit m_on, m_pend, m_trig, m_done, m_wrap;
  int m_cnt, m_since, m_post, m_wp;
  logic [31:0] m_mem [DEPTH];
  int cfg_sync, cfg_post;
  logic [31:0] pc_q;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_on = 0; m_pend = 0; m_trig = 0; m_done = 0; m_wrap = 0;
    m_cnt = 0; m_since = 0; m_post = 0; m_wp = 0;
  endtask

  task automatic model_step(input logic v, input logic [31:0] pc, input logic tk,
                            input logic [31:0] tgt, input logic st, input logic sp, input logic tr);
    bit fire, o_trig, o_done, wv;
    logic [31:0] w, npc;
    fire = v && m_on && !m_done;
    o_trig = m_trig; o_done = m_done; wv = 0; w = 0;
    npc = tk ? tgt : pc + 32'd4;
    if (fire) begin
      if (m_pend || (cfg_sync != 0 && m_since >= cfg_sync)) begin
        wv = 1; w = {2'b10, npc[31:2]};
        m_pend = 0; m_since = 0; m_cnt = 0;
      end else begin
        if (tk) begin wv = 1; w = {2'b01, 8'(m_cnt), tgt[23:2]}; m_cnt = 0; end
        else if (m_cnt == 255) begin wv = 1; w = {2'b11, 8'hFF, 22'h0}; m_cnt = 1; end
        else m_cnt++;
        if (wv && m_since < 255) m_since++;
      end
    end
    if (wv) begin
      m_mem[m_wp] = w;
      m_wp = (m_wp + 1) % DEPTH;
      if (m_wp == 0) m_wrap = 1;
      if (o_trig && !o_done) begin
        m_post++;
        if (m_post == cfg_post) m_done = 1;
      end
    end
    if (tr && !o_trig && !o_done) begin
      m_trig = 1;
      if (cfg_post == 0) m_done = 1;
    end
    if (st && !sp && !m_on && !o_done) m_pend = 1;
    if (sp) m_on = 0; else if (st) m_on = 1;
  endtask

  task automatic step(input logic v, input logic [31:0] pc, input logic tk,
                      input logic [31:0] tgt, input logic st, input logic sp, input logic tr);
    @(negedge clk);
    instr_valid = v; instr_pc = pc; instr_taken = tk; instr_target = tgt;
    start_evt = st; stop_evt = sp; trig_evt = tr;
    model_step(v, pc, tk, tgt, st, sp, tr);
    @(posedge clk); #1;
    check({rec_active, cap_done, buf_wrapped} == {m_on && !m_done, m_done, m_wrap},
          "R6/R7/R8 flags", {29'd0, rec_active, cap_done, buf_wrapped},
          {29'd0, m_on && !m_done, m_done, m_wrap});
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic run_stream(input int n, input int bprob, input int trig_at);
    for (int i = 0; i < n; i++) begin
      logic tk;
      logic [31:0] tg;
      tk = (int'($urandom_range(99)) < bprob);
      tg = $urandom & 32'hFFFF_FFFC;
      step(1'b1, pc_q, tk, tg, 1'b0, 1'b0, i == trig_at);
      pc_q = tk ? tg : pc_q + 32'd4;
    end
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic dump_check(input string tag);
    logic [31:0] d;
    int exp_fill, oldest;
    idle();
    exp_fill = m_wrap ? DEPTH : m_wp;
    oldest = m_wrap ? m_wp : 0;
    bus_read(2'd3, d);
    check(d == 32'(exp_fill), {tag, " R9 fill"}, d, 32'(exp_fill));
    bus_write(2'd1, '0);
    for (int i = 0; i < exp_fill; i++) begin
      bus_read(2'd2, d);
      check(d == m_mem[(oldest + i) % DEPTH], {tag, " R1/R10 entry"}, d, m_mem[(oldest + i) % DEPTH]);
    end
    bus_read(2'd0, d);
    check(d == {29'd0, m_trig, m_wrap, m_done}, {tag, " R9 status"}, d, {29'd0, m_trig, m_wrap, m_done});
  endtask

  task automatic do_reset(input int s, input int p);
    rst_n = 0;
    cfg_sync = s; cfg_post = p;
    sync_every = 8'(s); post_count = PW'(p);
    instr_valid = 0; start_evt = 0; stop_evt = 0; trig_evt = 0;
    model_clear();
    pc_q = 32'h0000_1000;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    // R11 reset state
    do_reset(0, 64);
    #1;
    check({rec_active, cap_done, buf_wrapped} == 3'b000, "R11 flags", {29'd0, rec_active, cap_done, buf_wrapped}, 0);
    bus_read(2'd3, d); check(d == 0, "R11 fill", d, 0);
    bus_read(2'd1, d); check(d == 0, "R11 index", d, 0);
    bus_read(2'd0, d); check(d == 0, "R11 status", d, 0);

    // R2 R3 R5: anchor at enable, branch records, periodic anchors every 4
    do_reset(4, 64);
    step(0, 0, 0, 0, 1, 0, 0);
    run_stream(120, 30, -1);
    dump_check("R2/R3/R5 mixed");

    // R4: run overflow then a branch carrying the remainder
    do_reset(0, 64);
    step(0, 0, 0, 0, 1, 0, 0);
    run_stream(300, 0, -1);
    step(1, pc_q, 1, 32'h00AB_CD10, 0, 0, 0);
    dump_check("R4 overflow");

    // R7: wrap with oldest-first readout
    do_reset(8, 64);
    step(0, 0, 0, 0, 1, 0, 0);
    run_stream(200, 50, -1);
    dump_check("R7 wrap");

    // R6: trigger with 10 post records, later instructions ignored
    do_reset(0, 10);
    step(0, 0, 0, 0, 1, 0, 0);
    run_stream(150, 60, 100);
    run_stream(20, 60, -1);
    dump_check("R6 post10");

    // R6: post_count zero
    do_reset(3, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    run_stream(60, 40, 30);
    dump_check("R6 post0");

    // R8 R2: stop and resume, stop wins over start
    do_reset(0, 64);
    step(0, 0, 0, 0, 1, 0, 0);
    run_stream(20, 40, -1);
    step(0, 0, 0, 0, 1, 1, 0);
    run_stream(15, 40, -1);
    step(0, 0, 0, 0, 1, 0, 0);
    run_stream(15, 40, -1);
    dump_check("R8 gating");

    // R10: index write then data read
    bus_write(2'd1, 6'd3);
    bus_read(2'd2, d);
    check(d == m_mem[3], "R10 indexed data", d, m_mem[3]);
    bus_read(2'd1, d);
    check(d == 32'd4, "R10 index increment", d, 32'd4);

    finish_run();
  end
endmodule